// File: doc/BRIEF.md
# Click-Sequenced LED Pattern Controller

This block drives a row of eight LEDs through a repeating cycle of display modes, all chosen with one push-button. Each press moves the controller one step along the cycle: dark, all lit, a single light running right, a single light running left, and a two-group flash in which the odd-position LEDs are dimmed. A fifth press returns to dark, and the cycle starts again.

The button is not read on every clock. It is re-timed to the clock and then looked at once per sample period, nominally 250 Hz when the clock is 50 MHz. A press counts only where one sample is high and the sample before it was low. Each display rate, the dimming square wave and the sample rate come from clock-enable dividers whose lengths are parameters given in clock cycles. The rate dividers restart on every press. An idle timer raises a power-down request once the controller has sat dark for a set number of sample periods, nominally two minutes.

Top module: `ledseq_ctrl`

## Requirements
- R1: The button is re-timed by two flip-flops and then captured once every SAMPLE_DIV cycles. A press is recognised only when a captured value is 1 and the previous captured value was 0, and the display changes on the second clock edge after that sample instant. A high pulse that falls between two sample instants has no effect.
- R2: After reset `led` is 8'h00 and `pwr_down` is 0.
- R3: In the second mode (one press from dark) `led` is 8'hFF.
- R4: Entering the right-running mode loads `led` with 8'h01 (bit 0 lit). Every SLOW_DIV cycles after the press, the lit bit moves from position n to n-1, and from bit 0 to bit 7.
- R5: Entering the left-running mode loads `led` with 8'h01. Every MID_DIV cycles after the press, the lit bit moves from position n to n+1, and from bit 7 to bit 0.
- R6: The flash mode starts with the even group lit at full strength (8'h55). Every FAST_DIV cycles it swaps between the even group and the odd group (mask 8'hAA). The two groups are never lit together.
- R7: While the odd group is selected, its LEDs follow a square wave with a half period of PWM_HALF cycles, starting low at the press. `led` is then only 8'hAA or 8'h00.
- R8: A press in the flash mode returns the controller to dark (8'h00).
- R9: `pwr_down` rises once IDLE_SAMPLES sample instants have passed in the dark mode. It stays high while dark and drops in the cycle the mode leaves dark.
- R10: A button held high through many sample periods advances the mode exactly once.
- R11: When a press and a rate step fall in the same cycle, the press wins: a rotate mode shows 8'h01 right after entry, and all rate timing restarts from the press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 1 | Raw push-button level, high while pressed |
| led | output | 8 | LED drive, bit n drives LED n |
| pwr_down | output | 1 | Request to remove power after the dark idle period |

## Verification
The case that needs the most care is a press that lands in the same cycle as a rotation step or flash swap. In that cycle the mode load and the step compete for the same register, and the rate divider is both ending its period and being cleared. The bench provokes this by cycling through all modes many times with a hold time that changes from run to run, so the press slides across every phase of the running rate divider. A behavioural model, driven only by cycle counts measured from each press, gives the LED value for every cycle. It is compared on every clock, with an extra check that each rotate entry shows 8'h01.

// File: rtl/ledseq_pkg.sv
package ledseq_pkg;

    localparam int N_LED = 8;

    typedef enum logic [2:0] {
        M_DARK  = 3'd0,
        M_SOLID = 3'd1,
        M_RIGHT = 3'd2,
        M_LEFT  = 3'd3,
        M_FLASH = 3'd4
    } mode_e;

    typedef struct packed {
        logic [N_LED-1:0] ring;
        logic             phase;
        logic             pwm;
    } pattern_s;

    function automatic mode_e mode_after(input mode_e m);
        case (m)
            M_DARK:  return M_SOLID;
            M_SOLID: return M_RIGHT;
            M_RIGHT: return M_LEFT;
            M_LEFT:  return M_FLASH;
            default: return M_DARK;
        endcase
    endfunction

    function automatic logic is_rotating(input mode_e m);
        return (m == M_RIGHT) || (m == M_LEFT);
    endfunction

    function automatic logic [N_LED-1:0] step_right(input logic [N_LED-1:0] v);
        return {v[0], v[N_LED-1:1]};
    endfunction

    function automatic logic [N_LED-1:0] step_left(input logic [N_LED-1:0] v);
        return {v[N_LED-2:0], v[N_LED-1]};
    endfunction

    function automatic logic [N_LED-1:0] group_mask(input logic odd);
        logic [N_LED-1:0] m;
        for (int i = 0; i < N_LED; i++) m[i] = ((i % 2) == 1) == odd;
        return m;
    endfunction

endpackage

// File: rtl/ledseq_divider.sv
module ledseq_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/ledseq_button.sv
module ledseq_button #(
    parameter int SAMPLE_DIV = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic sample_tick,
    output logic click
);
    logic [1:0] sync_q;
    logic       held_q;

    ledseq_divider #(.DIV(SAMPLE_DIV)) u_sample (
        .clk (clk),
        .rst (rst),
        .clr (1'b0),
        .tick(sample_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            held_q <= 1'b0;
            click  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], btn};
            click  <= sample_tick && sync_q[1] && !held_q;
            if (sample_tick) held_q <= sync_q[1];
        end
    end
endmodule

// File: rtl/ledseq_pattern.sv
module ledseq_pattern
    import ledseq_pkg::*;
#(
    parameter int SLOW_DIV = 20000000,
    parameter int MID_DIV  = 10000000,
    parameter int FAST_DIV = 6666667,
    parameter int PWM_HALF = 25000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             click,
    input  mode_e            mode,
    input  mode_e            mode_next,
    output logic [N_LED-1:0] led
);
    localparam int N_RATE = 3;
    localparam int RATE_DIV [N_RATE] = '{SLOW_DIV, MID_DIV, FAST_DIV};

    logic [N_RATE-1:0] rate_tick;
    logic              pwm_tick;
    pattern_s          pat_q;

    for (genvar g = 0; g < N_RATE; g++) begin : g_rate
        ledseq_divider #(.DIV(RATE_DIV[g])) u_div (
            .clk (clk),
            .rst (rst),
            .clr (click),
            .tick(rate_tick[g])
        );
    end

    ledseq_divider #(.DIV(PWM_HALF)) u_pwm (
        .clk (clk),
        .rst (rst),
        .clr (click),
        .tick(pwm_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (click) begin
            if (is_rotating(mode_next)) pat_q.ring <= N_LED'(1);
            pat_q.phase <= 1'b0;
            pat_q.pwm   <= 1'b0;
        end else begin
            if (mode == M_RIGHT && rate_tick[0]) pat_q.ring <= step_right(pat_q.ring);
            if (mode == M_LEFT && rate_tick[1])  pat_q.ring <= step_left(pat_q.ring);
            if (mode == M_FLASH && rate_tick[2]) pat_q.phase <= !pat_q.phase;
            if (pwm_tick) pat_q.pwm <= !pat_q.pwm;
        end
    end

    always_comb begin
        case (mode)
            M_SOLID:        led = '1;
            M_RIGHT,
            M_LEFT:         led = pat_q.ring;
            M_FLASH:        led = pat_q.phase ? (group_mask(1'b1) & {N_LED{pat_q.pwm}})
                                              : group_mask(1'b0);
            default:        led = '0;
        endcase
    end
endmodule

// File: rtl/ledseq_idle.sv
module ledseq_idle #(
    parameter int IDLE_SAMPLES = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic is_dark,
    input  logic sample_tick,
    output logic pwr_down
);
    localparam int IW = $clog2(IDLE_SAMPLES + 1);
    localparam logic [IW-1:0] LIMIT = IW'(IDLE_SAMPLES);

    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !is_dark)                 cnt <= '0;
        else if (sample_tick && cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign pwr_down = is_dark && (cnt == LIMIT);
endmodule

// File: rtl/ledseq_ctrl.sv
module ledseq_ctrl
    import ledseq_pkg::*;
#(
    parameter int SAMPLE_DIV   = 200000,
    parameter int SLOW_DIV     = 20000000,
    parameter int MID_DIV      = 10000000,
    parameter int FAST_DIV     = 6666667,
    parameter int PWM_HALF     = 25000,
    parameter int IDLE_SAMPLES = 30000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn,
    output logic [7:0] led,
    output logic       pwr_down
);
    logic  sample_tick;
    logic  click;
    mode_e mode_q;
    mode_e mode_next;

    ledseq_button #(.SAMPLE_DIV(SAMPLE_DIV)) u_button (
        .clk        (clk),
        .rst        (rst),
        .btn        (btn),
        .sample_tick(sample_tick),
        .click      (click)
    );

    assign mode_next = mode_after(mode_q);

    always_ff @(posedge clk) begin
        if (rst)        mode_q <= M_DARK;
        else if (click) mode_q <= mode_next;
    end

    ledseq_pattern #(
        .SLOW_DIV(SLOW_DIV),
        .MID_DIV (MID_DIV),
        .FAST_DIV(FAST_DIV),
        .PWM_HALF(PWM_HALF)
    ) u_pattern (
        .clk      (clk),
        .rst      (rst),
        .click    (click),
        .mode     (mode_q),
        .mode_next(mode_next),
        .led      (led)
    );

    ledseq_idle #(.IDLE_SAMPLES(IDLE_SAMPLES)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .is_dark    (mode_q == M_DARK),
        .sample_tick(sample_tick),
        .pwr_down   (pwr_down)
    );
endmodule

// File: rtl/ledseq_ctrl_chk.sv
module ledseq_ctrl_chk
    import ledseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] led,
    input logic       pwr_down,
    input mode_e      mode,
    input logic       click
);
    // R10: a press produces a single-cycle advance pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        click |=> !click);

    // R4: rotate modes always show exactly one lit LED
    a_r4_one_lit: assert property (@(posedge clk) disable iff (rst)
        is_rotating(mode) |-> ($countones(led) == 1));

    // R4: a change inside the right-running mode is one step right
    a_r4_step_right: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RIGHT && $past(mode) == M_RIGHT && !$past(click) && led != $past(led))
        |-> (led == {$past(led[0]), $past(led[7:1])}));

    // R5: a change inside the left-running mode is one step left
    a_r5_step_left: assert property (@(posedge clk) disable iff (rst)
        (mode == M_LEFT && $past(mode) == M_LEFT && !$past(click) && led != $past(led))
        |-> (led == {$past(led[6:0]), $past(led[7])}));

    // R6: even and odd groups are never lit together in the flash mode
    a_r6_groups_apart: assert property (@(posedge clk) disable iff (rst)
        (mode == M_FLASH && (led & 8'h55) != 8'h00) |-> ((led & 8'hAA) == 8'h00));

    // R8: a press in the flash mode leads to dark
    a_r8_wrap_dark: assert property (@(posedge clk) disable iff (rst)
        (click && mode == M_FLASH) |=> (led == 8'h00));

    // R9: the power-down request is only raised while dark
    a_r9_dark_only: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (led == 8'h00 && mode == M_DARK));

    // R11: entering a rotate mode always shows bit 0
    a_r11_entry_load: assert property (@(posedge clk) disable iff (rst)
        (click && is_rotating(mode_after(mode))) |=> (led == 8'h01));
endmodule

bind ledseq_ctrl ledseq_ctrl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .led     (led),
    .pwr_down(pwr_down),
    .mode    (mode_q),
    .click   (click)
);

// File: tb/ledseq_ctrl_tb_top.sv
module ledseq_ctrl_tb_top;
    localparam int SD   = 8;
    localparam int SLOW = 48;
    localparam int MID  = 24;
    localparam int FAST = 16;
    localparam int PWMH = 3;
    localparam int IDLE = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn = 1'b0;
    logic [7:0] led;
    logic       pwr_down;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ledseq_ctrl #(
        .SAMPLE_DIV(SD), .SLOW_DIV(SLOW), .MID_DIV(MID),
        .FAST_DIV(FAST), .PWM_HALF(PWMH), .IDLE_SAMPLES(IDLE)
    ) dut_i (
        .clk(clk), .rst(rst), .btn(btn), .led(led), .pwr_down(pwr_down)
    );

    // behavioural reference: counts cycles since the last press
    int         m_sc, m_mode, m_rc, m_idle;
    logic       m_s1, m_s2, m_smp, m_click;
    logic [7:0] m_rot;
    wire        m_tick = (m_sc == SD - 1);

    always @(posedge clk) begin
        if (rst) begin
            m_sc <= 0; m_mode <= 0; m_rc <= 0; m_idle <= 0;
            m_s1 <= 0; m_s2 <= 0; m_smp <= 0; m_click <= 0; m_rot <= 8'h00;
        end else begin
            m_sc    <= m_tick ? 0 : m_sc + 1;
            m_s1    <= btn;
            m_s2    <= m_s1;
            m_click <= m_tick && m_s2 && !m_smp;
            if (m_tick) m_smp <= m_s2;
            if (m_click) begin
                m_mode <= (m_mode + 1) % 5;
                m_rc   <= 0;
                if (m_mode == 1 || m_mode == 2) m_rot <= 8'h01;
            end else begin
                m_rc <= m_rc + 1;
                if (m_mode == 2 && (m_rc % SLOW) == SLOW - 1) m_rot <= {m_rot[0], m_rot[7:1]};
                if (m_mode == 3 && (m_rc % MID) == MID - 1)   m_rot <= {m_rot[6:0], m_rot[7]};
            end
            if (m_mode != 0)                   m_idle <= 0;
            else if (m_tick && m_idle < IDLE)  m_idle <= m_idle + 1;
        end
    end

    function automatic logic [7:0] model_led();
        logic ph, pw;
        ph = ((m_rc / FAST) % 2) == 1;
        pw = ((m_rc / PWMH) % 2) == 1;
        case (m_mode)
            1:       return 8'hFF;
            2, 3:    return m_rot;
            4:       return ph ? (pw ? 8'hAA : 8'h00) : 8'h55;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string mode_req(input int m);
        case (m)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(led == model_led(), mode_req(m_mode), led, model_led());
            check(pwr_down == (m_mode == 0 && m_idle == IDLE), "R9", pwr_down,
                  (m_mode == 0 && m_idle == IDLE));
            if ((m_mode == 2 || m_mode == 3) && m_rc == 0 && $time > 40)
                check(led == 8'h01, "R11", led, 8'h01);
        end
    end

    task automatic press(input int hold);
        btn = 1'b1;
        repeat (hold) @(negedge clk);
        btn = 1'b0;
        repeat (3 * SD) @(negedge clk);
    endtask

    task automatic wait_change(output int n);
        logic [7:0] p;
        p = led;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (led == p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int n_aa, n_zero, n_other;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(led == 8'h00, "R2", led, 8'h00);
        check(pwr_down == 1'b0, "R2", pwr_down, 0);

        press(3 * SD);
        check(led == 8'hFF, "R3", led, 8'hFF);

        // R1: short pulse placed between sample instants
        while (m_sc != SD - 1) @(negedge clk);
        btn = 1'b1;
        repeat (2) @(negedge clk);
        btn = 1'b0;
        repeat (3 * SD) @(negedge clk);
        check(led == 8'hFF, "R1", led, 8'hFF);

        // R4 and R10: held button, right rotation
        btn = 1'b1;
        wait_change(n);
        check(led == 8'h01, "R4", led, 8'h01);
        wait_change(n);
        check(led == 8'h80, "R4", led, 8'h80);
        wait_change(n);
        check(led == 8'h40, "R10", led, 8'h40);
        check(n == SLOW, "R4", n, SLOW);
        btn = 1'b0;
        repeat (3 * SD) @(negedge clk);

        // R5: left rotation
        btn = 1'b1;
        wait_change(n);
        check(led == 8'h01, "R5", led, 8'h01);
        wait_change(n);
        check(led == 8'h02, "R5", led, 8'h02);
        wait_change(n);
        check(led == 8'h04, "R5", led, 8'h04);
        check(n == MID, "R5", n, MID);
        btn = 1'b0;
        repeat (3 * SD) @(negedge clk);

        // R6 and R7: flash
        btn = 1'b1;
        do @(negedge clk); while (m_mode != 4);
        check(led == 8'h55, "R6", led, 8'h55);
        wait_change(n);
        check((led & 8'h55) == 8'h00, "R6", led, 8'hAA);
        n_aa = 0; n_zero = 0; n_other = 0;
        for (int i = 0; i < 12; i++) begin
            if (led == 8'hAA) n_aa++;
            else if (led == 8'h00) n_zero++;
            else n_other++;
            @(negedge clk);
        end
        check(n_aa > 0 && n_zero > 0 && n_other == 0, "R7", n_other, 0);
        btn = 1'b0;
        repeat (3 * SD) @(negedge clk);

        // R8: back to dark
        press(3 * SD);
        check(led == 8'h00, "R8", led, 8'h00);

        // R9: idle power-down and wake
        repeat (IDLE * SD + 2 * SD) @(negedge clk);
        check(pwr_down == 1'b1, "R9", pwr_down, 1);
        press(3 * SD);
        check(pwr_down == 1'b0 && led == 8'hFF, "R9", pwr_down, 0);

        // R11: presses sliding across every divider phase
        for (int k = 0; k < 30; k++) press(2 * SD + k);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule